// File: doc/BRIEF.md
# Byte-Counted I2C Master

This block is an I2C bus master that runs a complete transfer from a single launch pulse. Before launching, the host presents a target address, a count of data bytes (written as the count less one), a memory-address byte with a flag that skips it, and a clock divider. A launch pulse with a direction bit then starts the transfer. The controller sends START, the address byte with the read/write bit, the optional memory-address byte and the data bytes. After the last counted byte it sends STOP without any further command.

Write data enters through a one-byte valid/ready stream, and read data leaves through another. In each stream a byte moves on a clock edge where both valid and ready are high. Back-pressure is carried by ready and valid, not by software polling. When the write buffer is empty, SCL is held low until the next byte arrives. When a received byte is still unread, SCL is held low and the next byte is not clocked. Busy and acknowledge-error stay as plain level outputs. The bus pins are active-high pull-down enables for an open-drain pad, together with a sample of the SDA line.

Top module: `i2c_burst_master`

## Requirements
- R1: A launch pulse is ignored when `dev_addr` is above 127 (bit 7 set) or when a transfer is already running. The ignored pulse produces no bus activity and no change to `busy`.
- R2: `byte_cnt` holds the number of data bytes minus one, so a value of 0 moves exactly one data byte.
- R3: `start_rd` = 0 selects a write and 1 selects a read. The address byte is the 7-bit address in bits 7..1 with the read/write bit (1 = read) in bit 0, and every byte is sent MSB first.
- R4: `busy` rises the cycle after an accepted launch and falls only after STOP has completed. While `busy` is low, both pull-down enables are low.
- R5: During a write, `wr_ready` is high only while the single write buffer is empty and counted bytes remain to be taken. After a byte is accepted, `wr_ready` stays low until that byte has moved into the shifter.
- R6: `rx_valid` rises when a received byte is placed on `rx_data`. While `rx_ready` is low, `rx_valid` and `rx_data` hold and no further SCL pulses occur.
- R7: On reads, the master acknowledges (SDA low) every received byte except the last, and leaves SDA released (NACK) on the last byte before STOP.
- R8: If the target does not acknowledge the address byte, the memory-address byte or a written data byte, `ack_err` is set, the remaining bytes are dropped, STOP is sent and `busy` falls. `ack_err` clears on the next accepted launch.
- R9: With `skip_mem` = 0, a write sends the memory-address byte right after the address byte. A read sends address+write, then the memory-address byte, then a repeated START, then address+read. With `skip_mem` = 1, data follows the address byte directly.
- R10: One SCL period lasts 4*floor(`clk_div`/4) system clocks, with a minimum of 4.
- R11: An active-low reset returns the block to idle. Both lines are released, and `busy`, `ack_err`, `wr_ready` and `rx_valid` are all low.
- R12: Within a byte, SDA changes only while SCL is held low. Each transfer therefore shows exactly the START, repeated START and STOP edges that its format calls for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse |
| start_rd | input | 1 | Direction for the launch: 1 read, 0 write |
| dev_addr | input | 8 | Target address; values above 127 are rejected |
| mem_addr | input | 8 | Memory-address byte |
| skip_mem | input | 1 | 1 omits the memory-address phase |
| byte_cnt | input | CNT_W | Data byte count minus one |
| clk_div | input | DIV_W | System clocks per SCL period |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write buffer empty and bytes still due |
| wr_data | input | 8 | Write byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| ack_err | output | 1 | Target failed to acknowledge |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest cases to reach from the ports are a target that refuses a byte in the middle of a stream and a consumer that stalls a read while SCL is parked low. The bench's target model can refuse any chosen byte position within a frame, so one test aborts a four-byte write at its third byte. In another read test the consumer withholds ready. The bench counts SCL rising edges through a long stall to show that the bus stays frozen, and then checks the acknowledge pattern the target logged once the stall is released.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_STOP  = 2'd1,
    PH_WBYTE = 2'd2,
    PH_RBYTE = 2'd3
  } phy_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_START   = 3'd1,
    ST_DEV     = 3'd2,
    ST_MEM     = 3'd3,
    ST_RESTART = 3'd4,
    ST_DEVR    = 3'd5,
    ST_DATA    = 3'd6,
    ST_STOP    = 3'd7
  } seq_state_e;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2cm_clkgen.sv
module i2cm_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int QSHIFT = 2;  // four quarter phases per SCL period

  logic [DIV_W-1:0] quarter;
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] cnt;

  assign quarter = div >> QSHIFT;
  assign limit   = (quarter == '0) ? '0 : quarter - DIV_W'(1);
  assign tick    = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R10: ticks are spaced by the quarter length; a tick never repeats back to back unless quarter is one
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (quarter > DIV_W'(1))) |=> !tick);
endmodule

// File: rtl/i2cm_phy.sv
module i2cm_phy
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  phy_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_nack,
  input  logic       sda_in,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       rx_nack,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);

  phy_op_e    op;
  logic [1:0] step;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       nack_q;
  logic       is_byte;

  assign is_byte = (op == PH_WBYTE) || (op == PH_RBYTE);
  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      done    <= 1'b0;
      op      <= PH_START;
      step    <= 2'd0;
      bitn    <= 4'd0;
      sh      <= 8'd0;
      nack_q  <= 1'b0;
      rx_nack <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (cmd_valid) begin
          active <= 1'b1;
          op     <= cmd_op;
          sh     <= cmd_byte;
          nack_q <= cmd_nack;
          step   <= 2'd0;
          bitn   <= 4'd0;
        end
      end else if (tick) begin
        step <= step + 2'd1;
        if (op == PH_START) begin
          case (step)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe <= 1'b1;
              active <= 1'b0;
              done   <= 1'b1;
            end
          endcase
        end else if (op == PH_STOP) begin
          case (step)
            2'd0: begin
              scl_oe <= 1'b1;
              sda_oe <= 1'b1;
            end
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          endcase
        end else begin
          case (step)
            2'd0: begin
              scl_oe <= 1'b1;
              if (bitn == ACK_SLOT) begin
                sda_oe <= (op == PH_RBYTE) && !nack_q;
              end else begin
                sda_oe <= (op == PH_WBYTE) && !sh[7];
              end
            end
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (bitn == ACK_SLOT) begin
                rx_nack <= sda_in;
              end else begin
                sh <= {sh[6:0], sda_in};
              end
            end
            default: begin
              scl_oe <= 1'b1;
              if (bitn == ACK_SLOT) begin
                active <= 1'b0;
                done   <= 1'b1;
              end else begin
                bitn <= bitn + 4'd1;
              end
            end
          endcase
        end
      end
    end
  end

  // R12: inside a byte, SDA holds while SCL is released
  p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_byte && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rd,
  input  logic [7:0]       dev_addr,
  input  logic [7:0]       mem_addr,
  input  logic             skip_mem,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             ack_err,
  output logic             cmd_valid,
  output phy_op_e          cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  input  logic             phy_done,
  input  logic [7:0]       phy_rx_byte,
  input  logic             phy_rx_nack
);
  localparam int LD_W = CNT_W + 1;

  seq_state_e       state;
  logic             pending;
  logic             is_rd;
  logic             skip_q;
  logic [6:0]       addr_q;
  logic [7:0]       mem_q;
  logic [7:0]       tx_buf;
  logic             tx_full;
  logic [CNT_W-1:0] rem;
  logic [LD_W-1:0]  load_left;
  logic             launch;

  assign launch   = start && (state == ST_IDLE) && !dev_addr[7];
  assign busy     = (state != ST_IDLE);
  assign wr_ready = busy && (state != ST_STOP) && !is_rd && !tx_full && (load_left != '0);

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = PH_START;
    cmd_byte  = 8'd0;
    cmd_nack  = 1'b0;
    if (!pending) begin
      unique case (state)
        ST_START, ST_RESTART: cmd_valid = 1'b1;
        ST_DEV: begin
          cmd_valid = 1'b1;
          cmd_op    = PH_WBYTE;
          cmd_byte  = {addr_q, is_rd & skip_q};
        end
        ST_MEM: begin
          cmd_valid = 1'b1;
          cmd_op    = PH_WBYTE;
          cmd_byte  = mem_q;
        end
        ST_DEVR: begin
          cmd_valid = 1'b1;
          cmd_op    = PH_WBYTE;
          cmd_byte  = {addr_q, 1'b1};
        end
        ST_DATA: begin
          if (is_rd) begin
            cmd_valid = !rx_valid;
            cmd_op    = PH_RBYTE;
            cmd_nack  = (rem == '0);
          end else begin
            cmd_valid = tx_full;
            cmd_op    = PH_WBYTE;
            cmd_byte  = tx_buf;
          end
        end
        ST_STOP: begin
          cmd_valid = 1'b1;
          cmd_op    = PH_STOP;
        end
        default: cmd_valid = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pending   <= 1'b0;
      is_rd     <= 1'b0;
      skip_q    <= 1'b0;
      addr_q    <= 7'd0;
      mem_q     <= 8'd0;
      tx_buf    <= 8'd0;
      tx_full   <= 1'b0;
      rem       <= '0;
      load_left <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= 8'd0;
      ack_err   <= 1'b0;
    end else if (launch) begin
      state     <= ST_START;
      pending   <= 1'b0;
      is_rd     <= start_rd;
      skip_q    <= skip_mem;
      addr_q    <= dev_addr[6:0];
      mem_q     <= mem_addr;
      tx_full   <= 1'b0;
      rem       <= byte_cnt;
      load_left <= {1'b0, byte_cnt} + LD_W'(1);
      ack_err   <= 1'b0;
    end else begin
      if (cmd_valid) pending <= 1'b1;
      if (wr_valid && wr_ready) begin
        tx_buf    <= wr_data;
        tx_full   <= 1'b1;
        load_left <= load_left - LD_W'(1);
      end
      if (cmd_valid && (state == ST_DATA) && !is_rd) tx_full <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (phy_done) begin
        pending <= 1'b0;
        unique case (state)
          ST_START: state <= ST_DEV;
          ST_DEV: begin
            if (phy_rx_nack) begin
              ack_err <= 1'b1;
              state   <= ST_STOP;
            end else begin
              state <= skip_q ? ST_DATA : ST_MEM;
            end
          end
          ST_MEM: begin
            if (phy_rx_nack) begin
              ack_err <= 1'b1;
              state   <= ST_STOP;
            end else begin
              state <= is_rd ? ST_RESTART : ST_DATA;
            end
          end
          ST_RESTART: state <= ST_DEVR;
          ST_DEVR: begin
            if (phy_rx_nack) begin
              ack_err <= 1'b1;
              state   <= ST_STOP;
            end else begin
              state <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (is_rd) begin
              rx_valid <= 1'b1;
              rx_data  <= phy_rx_byte;
            end
            if (!is_rd && phy_rx_nack) begin
              ack_err <= 1'b1;
              state   <= ST_STOP;
            end else if (rem == '0) begin
              state <= ST_STOP;
            end else begin
              rem <= rem - CNT_W'(1);
            end
          end
          ST_STOP: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: a launch with an out-of-range address leaves the block idle
  p_bad_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dev_addr[7]) |=> !busy);

  // R5: an accepted write byte closes the buffer on the next cycle
  p_tx_one_deep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R6: a held received byte does not change or vanish
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R8: an acknowledge error appears only together with the closing STOP phase
  p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_err) |-> (state == ST_STOP) && !wr_ready);
endmodule

// File: rtl/i2c_burst_master.sv
module i2c_burst_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rd,
  input  logic [7:0]       dev_addr,
  input  logic [7:0]       mem_addr,
  input  logic             skip_mem,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             ack_err,
  output logic             scl_oe,
  input  logic             sda_in,
  output logic             sda_oe
);
  logic       tick;
  logic       phy_active;
  logic       phy_done;
  logic [7:0] phy_rx_byte;
  logic       phy_rx_nack;
  logic       cmd_valid;
  phy_op_e    cmd_op;
  logic [7:0] cmd_byte;
  logic       cmd_nack;

  i2cm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (phy_active),
    .div   (clk_div),
    .tick  (tick)
  );

  i2cm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_rd    (start_rd),
    .dev_addr    (dev_addr),
    .mem_addr    (mem_addr),
    .skip_mem    (skip_mem),
    .byte_cnt    (byte_cnt),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_data     (wr_data),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .busy        (busy),
    .ack_err     (ack_err),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_byte    (cmd_byte),
    .cmd_nack    (cmd_nack),
    .phy_done    (phy_done),
    .phy_rx_byte (phy_rx_byte),
    .phy_rx_nack (phy_rx_nack)
  );

  i2cm_phy u_phy (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_nack  (cmd_nack),
    .sda_in    (sda_in),
    .active    (phy_active),
    .done      (phy_done),
    .rx_byte   (phy_rx_byte),
    .rx_nack   (phy_rx_nack),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  // R4: with no transfer running, both lines are released
  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_i2c_burst_master.sv
module tb_i2c_burst_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_rd = 1'b0, skip_mem = 1'b1;
  logic [7:0] dev_addr = 8'h50, mem_addr = 8'h00;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic [DIV_W-1:0] clk_div = DIV_W'(8);
  logic wr_valid, wr_ready, rx_valid, rx_ready = 1'b0, busy, ack_err, scl_oe, sda_oe;
  logic [7:0] wr_data, rx_data;
  logic s_pull = 1'b0;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | s_pull);

  i2c_burst_master #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd), .dev_addr(dev_addr),
    .mem_addr(mem_addr), .skip_mem(skip_mem), .byte_cnt(byte_cnt), .clk_div(clk_div),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .busy(busy), .ack_err(ack_err),
    .scl_oe(scl_oe), .sda_in(sda_w), .sda_oe(sda_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  always @(negedge clk) cyc++;

  // write-stream feeder
  logic [7:0] tx_q [0:15];
  int tx_n = 0, tx_i = 0;
  logic feed_on = 1'b0;
  assign wr_valid = feed_on && (tx_i < tx_n);
  assign wr_data  = tx_q[tx_i[3:0]];
  always @(posedge clk) if (wr_valid && wr_ready) tx_i <= tx_i + 1;

  // read-stream collector
  logic [7:0] rx_got [0:15];
  int rx_n = 0;
  always @(posedge clk) if (rx_valid && rx_ready) begin rx_got[rx_n[3:0]] <= rx_data; rx_n <= rx_n + 1; end

  // target model
  logic [7:0] wlog [0:31];
  logic mack [0:15];
  int wn, mn, starts, stops, rises, nrise, rise_t0, rise_t1;
  int fb, bc, di, nack_idx = -1;
  logic ps_scl = 1'b1, ps_sda = 1'b1, ign = 1'b1, sending = 1'b0, rdm = 1'b0, nacked = 1'b0, lastm = 1'b0;
  logic [7:0] shr, rdb, sl_base = 8'h00;

  function automatic logic [7:0] rdv(input int i);
    return sl_base + 8'(i) * 8'h1D;
  endfunction

  always @(scl_w or sda_w) begin
    if (scl_w && ps_scl && ps_sda && !sda_w) begin
      starts++; fb = 0; bc = 0; sending = 0; ign = 0; rdm = 0; nacked = 0; s_pull = 0; nrise = 0;
    end else if (scl_w && ps_scl && !ps_sda && sda_w) begin
      stops++; sending = 0; ign = 1; s_pull = 0;
    end else if (scl_w && !ps_scl) begin
      rises++;
      if (nrise == 0) rise_t0 = cyc; else if (nrise == 1) rise_t1 = cyc;
      nrise++;
      if (!ign) begin
        if (bc < 8) begin
          if (!sending) shr = {shr[6:0], sda_w};
          bc++;
        end else begin
          if (sending) begin lastm = sda_w; if (mn < 16) mack[mn] = sda_w; mn++; end
          bc = 9;
        end
      end
    end else if (!scl_w && ps_scl && !ign) begin
      if (bc == 8) begin
        if (!sending) begin
          if (wn < 32) wlog[wn] = shr;
          wn++;
          if (fb == 0) rdm = shr[0];
          nacked = (fb == nack_idx);
          s_pull = !nacked;
        end else s_pull = 0;
      end else if (bc == 9) begin
        s_pull = 0; bc = 0;
        if (nacked) ign = 1;
        else if (sending) begin if (lastm) sending = 0; else di++; end
        else if (fb == 0 && rdm) begin sending = 1; di = 0; end
        fb++;
        if (sending) begin rdb = rdv(di); s_pull = ~rdb[7]; end
      end else if (sending && bc > 0) begin
        rdb = rdv(di); s_pull = ~rdb[7 - bc];
      end
    end
    ps_scl = scl_w; ps_sda = sda_w;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic new_test();
    wn = 0; mn = 0; starts = 0; stops = 0; rises = 0; nrise = 0; nack_idx = -1;
    tx_n = 0; rx_n = 0; feed_on = 0;
    @(negedge clk); tx_i = 0;
  endtask

  task automatic launch(input logic rd, input logic [7:0] a, input logic skip, input int cnt);
    @(negedge clk);
    start_rd = rd; dev_addr = a; skip_mem = skip; byte_cnt = CNT_W'(cnt); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic load_tx(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) tx_q[k] = seed + 8'(k) * 8'h31;
    tx_n = n; feed_on = 1;
  endtask

  task automatic t_reset_state();
    chk(!busy && !ack_err, "R11 busy/err after reset", {busy, ack_err}, 0);
    chk(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    chk(!wr_ready && !rx_valid, "R11 streams idle", {wr_ready, rx_valid}, 0);
  endtask

  task automatic t_write_plain();
    new_test(); load_tx(3, 8'h12);
    launch(1'b0, 8'h50, 1'b1, 2);
    chk(busy, "R4 busy after launch", busy, 1);
    for (int k = 0; k < 2000 && tx_i < 1; k++) @(negedge clk);
    chk(!wr_ready, "R5 ready low while byte waits", wr_ready, 0);
    @(negedge clk); start_rd = 1; dev_addr = 8'h11; start = 1; @(negedge clk); start = 0;
    wait_idle();
    chk(wn == 4, "R2 byte count on bus", wn, 4);
    chk(wlog[0] == 8'hA0, "R3 address byte write", wlog[0], 8'hA0);
    for (int k = 0; k < 3; k++) chk(wlog[k+1] == tx_q[k], "R3 data MSB first", wlog[k+1], tx_q[k]);
    chk(starts == 1 && stops == 1, "R1 R12 one START one STOP", starts*16+stops, 17);
    chk(!busy && !ack_err, "R4 idle after stop", {busy, ack_err}, 0);
  endtask

  task automatic t_write_mem();
    new_test(); load_tx(2, 8'h5A); mem_addr = 8'h3C;
    launch(1'b0, 8'h2B, 1'b0, 1);
    wait_idle();
    chk(wn == 4, "R9 write frame length", wn, 4);
    chk(wlog[0] == 8'h56 && wlog[1] == 8'h3C, "R9 address then memory byte", {wlog[0], wlog[1]}, 16'h563C);
    chk(wlog[2] == tx_q[0] && wlog[3] == tx_q[1], "R9 data after memory byte", {wlog[2], wlog[3]}, {tx_q[0], tx_q[1]});
  endtask

  task automatic t_read_stall();
    int r0;
    logic [7:0] d0;
    new_test(); sl_base = 8'hC3; rx_ready = 0;
    launch(1'b1, 8'h50, 1'b1, 2);
    for (int k = 0; k < 5000 && !rx_valid; k++) @(negedge clk);
    d0 = rx_data; r0 = rises;
    chk(rx_valid && d0 == rdv(0), "R6 first byte presented", d0, rdv(0));
    repeat (300) @(negedge clk);
    chk(rx_valid && rx_data == d0, "R6 byte held under back-pressure", rx_data, d0);
    chk(rises == r0, "R6 no SCL pulses while stalled", rises, r0);
    rx_ready = 1;
    wait_idle();
    chk(rx_n == 3, "R2 read byte count", rx_n, 3);
    for (int k = 0; k < 3; k++) chk(rx_got[k] == rdv(k), "R3 read data", rx_got[k], rdv(k));
    chk(mn == 3 && !mack[0] && !mack[1] && mack[2], "R7 ACK ACK NACK", {mack[0], mack[1], mack[2]}, 3'b001);
    chk(wlog[0] == 8'hA1 && stops == 1, "R3 read address bit", wlog[0], 8'hA1);
  endtask

  task automatic t_read_mem();
    new_test(); sl_base = 8'h47; rx_ready = 1; mem_addr = 8'h9E;
    launch(1'b1, 8'h33, 1'b0, 1);
    wait_idle();
    chk(wn == 3, "R9 read preamble length", wn, 3);
    chk(wlog[0] == 8'h66 && wlog[1] == 8'h9E && wlog[2] == 8'h67, "R9 write-addr mem read-addr",
        {wlog[0], wlog[1], wlog[2]}, 24'h669E67);
    chk(starts == 2 && stops == 1, "R12 repeated START", starts*16+stops, 33);
    chk(rx_n == 2 && rx_got[0] == rdv(0) && rx_got[1] == rdv(1), "R9 read data", rx_got[1], rdv(1));
  endtask

  task automatic t_nack_addr();
    new_test(); nack_idx = 0; rx_ready = 1;
    launch(1'b1, 8'h41, 1'b1, 1);
    wait_idle();
    chk(ack_err && !busy, "R8 address NACK", {ack_err, busy}, 2'b10);
    chk(wn == 1 && mn == 0 && rx_n == 0 && stops == 1, "R8 nothing after address", wn*16+rx_n, 16);
  endtask

  task automatic t_nack_data();
    new_test(); nack_idx = 2; load_tx(4, 8'h07);
    launch(1'b0, 8'h50, 1'b1, 3);
    wait_idle();
    chk(ack_err && !busy, "R8 data NACK", {ack_err, busy}, 2'b10);
    chk(wn == 3 && stops == 1, "R8 rest dropped", wn, 3);
    chk(!wr_ready, "R8 stream closed", wr_ready, 0);
    feed_on = 0;
  endtask

  task automatic t_single();
    new_test(); load_tx(1, 8'hE4);
    launch(1'b0, 8'h7F, 1'b1, 0);
    wait_idle();
    chk(!ack_err, "R8 error cleared by launch", ack_err, 0);
    chk(wn == 2 && wlog[0] == 8'hFE && wlog[1] == 8'hE4, "R2 count zero is one byte", wn, 2);
  endtask

  task automatic t_bad_addr();
    new_test();
    launch(1'b0, 8'h85, 1'b1, 0);
    repeat (40) @(negedge clk);
    chk(!busy && starts == 0, "R1 address above 127 ignored", busy, 0);
  endtask

  task automatic t_period(input int dv, input int exp);
    new_test(); clk_div = DIV_W'(dv); load_tx(1, 8'h00);
    launch(1'b0, 8'h50, 1'b1, 0);
    wait_idle();
    chk(rise_t1 - rise_t0 == exp, "R10 SCL period", rise_t1 - rise_t0, exp);
    clk_div = DIV_W'(8);
  endtask

  task automatic t_reset_mid();
    new_test(); load_tx(4, 8'h21);
    launch(1'b0, 8'h50, 1'b1, 3);
    repeat (100) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!busy && !ack_err && !wr_ready && !rx_valid, "R11 flags cleared", {busy, ack_err}, 0);
    chk(!scl_oe && !sda_oe, "R11 lines released mid-transfer", {scl_oe, sda_oe}, 0);
    rst_n = 1; feed_on = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_write_plain();
    t_write_mem();
    t_read_stall();
    t_read_mem();
    t_nack_addr();
    t_nack_data();
    t_single();
    t_bad_addr();
    t_period(12, 12);
    t_period(14, 12);
    t_period(2, 4);
    t_reset_mid();
    report();
    $finish;
  end
endmodule